// File: doc/BRIEF.md
# Serial Bit-Pair Adder

This block adds two unsigned operands by working through them one bit pair per clock, least significant bit first. Both operands are loaded in parallel into shift registers while the block is idle. A start request then runs the addition for as many clocks as the operands have bits. A single carry flip-flop works as a two-state machine: carry clear or carry set. Each clock it produces the sum bit as a Mealy output of the carry state and the two current operand bits.

Each sum bit is shifted into the top of the first operand register, so that register holds the low part of the sum when the run ends. The second operand register empties in step with it. The final carry is kept as one extra result bit, which makes the full result one bit wider than the operands. A one-cycle done pulse marks the end of the run. Start and load requests that arrive while a run is in progress are dropped.

Top module: `serial_adder_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its registers. After that edge `result` is 0, `busy` is 0 and `done` is 0.
- R2: When `load` is high at an edge while the block is idle, `op_a` and `op_b` are captured. From the next cycle `result` reads `{1'b0, op_a}`.
- R3: When `start` is high and `load` is low at an edge while the block is idle, a run begins. `busy` is high for exactly W cycles, starting in the cycle after that edge.
- R4: The operands are added bit pair by bit pair, starting at bit 0. After a run, `result[W-1:0]` equals `(A + B) mod 2^W`.
- R5: After a run, `result[W]` holds the carry out of the most significant bit pair. `result` as a whole therefore equals A + B.
- R6: `done` is high for exactly one cycle. That cycle is the first cycle after the last bit pair, and `busy` is low in it.
- R7: The carry state is cleared when a run begins. A run that follows a run ending with carry 1 gives the correct sum.
- R8: A `start` request made while `busy` is high is ignored. The run ends at its normal time with the correct result.
- R9: A `load` request made while `busy` is high is ignored. The operands of the current run are not changed.
- R10: When `load` and `start` are both high at an idle edge, the load is taken and no run begins.
- R11: The carry moves from clear to set only when both operand bits are 1. It moves from set to clear only when both operand bits are 0. Otherwise it keeps its state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Parallel load of both operands (idle only) |
| start | input | 1 | Begin an addition (idle only) |
| op_a | input | W | First operand, parallel load value |
| op_b | input | W | Second operand, parallel load value |
| busy | output | 1 | High while bit pairs are being added |
| done | output | 1 | One-cycle pulse after the last bit pair |
| result | output | W+1 | Final carry over the first operand register |

## Verification
The assertions assume that `start` and `load` are single-bit levels sampled only at clock edges. They also assume no operand value matters while `load` is low. All clocked checks are disabled while `rst_n` is low. The bench drives every input on the falling edge, so each request is stable across the rising edge that samples it. Requests made during a run fall in the middle of the run and never on its first or last edge. The only exception is the deliberate load-with-start case, and that case stays within the idle state.

// File: rtl/sadd_pkg.sv
// Package: shared types for the serial adder.
// Assumes: nothing beyond IEEE 1800-2017.
package sadd_pkg;
    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/sadd_shift_regs.sv
// Module: operand shift registers.
// Loads both operands in parallel. While shifting, each register moves right
// by one bit. The first register takes the new sum bit at its top and the
// second register fills with zeros.
// Assumes: load_en and shift_en are never high together (the control ensures this).
module sadd_shift_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         shift_en,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sum_bit,
    output logic         a_lsb,
    output logic         b_lsb,
    output logic [W-1:0] a_q
);
    logic [W-1:0] b_q;

    // Purpose: parallel load or one-place right shift of both operand registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load_en) begin
            a_q <= op_a;
            b_q <= op_b;
        end else if (shift_en) begin
            a_q <= {sum_bit, a_q[W-1:1]};
            b_q <= {1'b0, b_q[W-1:1]};
        end
    end

    assign a_lsb = a_q[0];
    assign b_lsb = b_q[0];

    // R2: a load captures the operand presented at that edge
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (a_q == $past(op_a)) && (b_q == $past(op_b)));

    // R4: a shift step puts the sum bit at the top of the first register
    assert_sum_enters_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load_en) |=> a_q[W-1] == $past(sum_bit));
endmodule

// File: rtl/sadd_carry_fsm.sv
// Module: two-state carry machine.
// One flip-flop holds the carry, either clear or set. The sum bit is a Mealy
// output built from the carry state and the two current operand bits.
// Assumes: clr has priority over en.
module sadd_carry_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic a,
    input  logic b,
    output logic sum_bit,
    output logic carry_q,
    output logic carry_next
);
    // Purpose: Mealy sum output and majority next-state.
    always_comb begin
        sum_bit    = a ^ b ^ carry_q;
        carry_next = (a & b) | (a & carry_q) | (b & carry_q);
    end

    // Purpose: carry state register with clear at run start.
    always_ff @(posedge clk) begin
        if (!rst_n)      carry_q <= 1'b0;
        else if (clr)    carry_q <= 1'b0;
        else if (en)     carry_q <= carry_next;
    end

    // R11: from clear, only a 1/1 pair sets the carry
    assert_set_on_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !carry_q) |=> carry_q == $past(a & b));
    // R11: from set, only a 0/0 pair clears the carry
    assert_clear_on_none_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && carry_q) |=> carry_q == $past(a | b));
    // R7: a run start leaves the carry clear
    assert_clear_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !carry_q);
endmodule

// File: rtl/sadd_ctrl.sv
// Module: run control.
// Idle or running. In idle, load wins over start. A run lasts W cycles,
// counted by a bit counter, and ends with a one-cycle done pulse.
// Assumes: W >= 2.
module sadd_ctrl
    import sadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic start,
    output logic load_en,
    output logic run_begin,
    output logic shift_en,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

    ctl_state_t    state_q;
    logic [CW-1:0] cnt_q;

    // Purpose: decode the request strobes and the step enables from the state.
    always_comb begin
        load_en   = (state_q == CTL_IDLE) && load;
        run_begin = (state_q == CTL_IDLE) && !load && start;
        shift_en  = (state_q == CTL_RUN);
        last      = shift_en && (cnt_q == LAST_CNT);
        busy      = shift_en;
    end

    // Purpose: state, bit counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= last;
            if (run_begin) begin
                state_q <= CTL_RUN;
                cnt_q   <= '0;
            end else if (shift_en) begin
                cnt_q <= cnt_q + 1'b1;
                if (last) state_q <= CTL_IDLE;
            end
        end
    end

    // R6: done lasts one cycle and never overlaps busy
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)) ##1 !done);
    // R8: start during a run does not restart the count
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last && start) |=> busy && (cnt_q == $past(cnt_q) + 1'b1));
    // R10: load together with start in idle does not begin a run
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load && start) |=> !busy);
    // R3: a run begins with the counter at zero
    assert_run_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cnt_q == '0);
endmodule

// File: rtl/serial_adder_unit.sv
// Module: top of the serial adder.
// Connects the control, the carry machine and the operand shift registers.
// Keeps the final carry as the top result bit.
// Assumes: operands are unsigned; inputs are stable around the rising edge.
module serial_adder_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W:0]   result
);
    logic         load_en, run_begin, shift_en, last;
    logic         a_lsb, b_lsb, sum_bit, carry_q, carry_next;
    logic [W-1:0] a_q;
    logic         hi_q;

    sadd_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(load), .start(start),
        .load_en(load_en), .run_begin(run_begin), .shift_en(shift_en),
        .last(last), .busy(busy), .done(done)
    );

    sadd_carry_fsm u_carry (
        .clk(clk), .rst_n(rst_n), .clr(run_begin), .en(shift_en),
        .a(a_lsb), .b(b_lsb), .sum_bit(sum_bit),
        .carry_q(carry_q), .carry_next(carry_next)
    );

    sadd_shift_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .shift_en(shift_en),
        .op_a(op_a), .op_b(op_b), .sum_bit(sum_bit),
        .a_lsb(a_lsb), .b_lsb(b_lsb), .a_q(a_q)
    );

    // Purpose: top result bit, cleared on load or run start, set from the final carry.
    always_ff @(posedge clk) begin
        if (!rst_n)                   hi_q <= 1'b0;
        else if (load_en || run_begin) hi_q <= 1'b0;
        else if (last)                hi_q <= carry_next;
    end

    assign result = {hi_q, a_q};

    // R9: a load during a run leaves the operand register to the shift
    assert_load_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load) |=> result[W-2:0] == $past(result[W-1:1]));
    // R5: the top bit only changes at load, start or the last step
    assert_hi_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !run_begin && !last) |=> $stable(result[W]));
    // R1: after reset the block is idle with a zero result
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (result == '0) && !busy && !done);
endmodule

// File: tb/serial_adder_unit_tb.sv
module serial_adder_unit_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         busy, done;
    logic [W:0]   result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    serial_adder_unit #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .start(start),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .result(result)
    );

    // {a, b}: chosen to cover no carry, full ripple, carry into bit 8 and a
    // zero run right after a carry-out run (R7)
    localparam logic [15:0] VEC [10] = '{
        16'h0000, 16'h0102, 16'h0F01, 16'hFF01, 16'h0000,
        16'hFFFF, 16'h5555, 16'hAA55, 16'h80_80, 16'h3C_C3
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // poke: 0 none, 1 start mid-run (R8), 2 load mid-run (R9)
    task automatic run_add(input logic [7:0] a, input logic [7:0] b, input int poke);
        logic [8:0] exp_sum;
        exp_sum = {1'b0, a} + {1'b0, b};
        @(negedge clk); load = 1'b1; op_a = a; op_b = b; start = 1'b0;
        @(negedge clk); load = 1'b0;
        check(result == {1'b0, a}, "R2", "loaded result", result, {1'b0, a});
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R3", "busy after start", busy, 1);
        for (int k = 1; k <= W; k++) begin
            if (k == 3 && poke == 1) start = 1'b1;
            if (k == 3 && poke == 2) begin load = 1'b1; op_a = ~a; op_b = ~b; end
            @(negedge clk); start = 1'b0; load = 1'b0;
            if (k == W - 1)
                check(busy && !done, "R3", "busy through run", {busy, done}, 2'b10);
        end
        check(done && !busy, "R6", "done at end", {busy, done}, 2'b01);
        check(result[7:0] == exp_sum[7:0], "R4", "low sum", result[7:0], exp_sum[7:0]);
        check(result[8] == exp_sum[8], "R5", "carry out", result[8], exp_sum[8]);
        @(negedge clk);
        check(!done, "R6", "done one cycle", done, 0);
        check(result == exp_sum, "R11", "result held", result, exp_sum);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(result == '0 && !busy && !done, "R1", "reset state",
              {result, busy, done}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++)
            run_add(VEC[i][15:8], VEC[i][7:0], 0);

        // R7: carry-out run then zero run
        run_add(8'hFF, 8'hFF, 0);
        run_add(8'h00, 8'h01, 0);
        // R8: start during a run
        run_add(8'h7F, 8'h01, 1);
        // R9: load during a run
        run_add(8'h96, 8'h6A, 2);

        // R10: load and start together in idle
        @(negedge clk); load = 1'b1; start = 1'b1; op_a = 8'h21; op_b = 8'h12;
        @(negedge clk); load = 1'b0; start = 1'b0;
        check(!busy, "R10", "no run on load+start", busy, 0);
        check(result == 9'h021, "R10", "load taken", result, 9'h021);

        // R1: reset during a run
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(result == '0 && !busy && !done, "R1", "reset mid-run",
              {result, busy, done}, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule